// File: doc/BRIEF.md
# DRAM Impedance Calibration Sequencer

This unit sits beside the main command scheduler of a DDR3 memory controller and runs impedance-calibration sequences on a device with one or two ranks. Three sources start a sequence: a power-up pulse, a self-refresh-exit pulse, and an internal interval timer. Both pulses start a long calibration. The timer starts a short one. Each source is latched until it is served, so a request is not lost while another sequence runs.

Once a source is pending, the unit raises a request to the command arbiter. When the grant arrives it walks the ranks in order. For each rank it closes any open banks with a precharge-all and waits the row-precharge time. It then issues the calibration command and keeps the channel quiet for the window length that belongs to that kind of calibration. During the sequence it forces CKE high and ODT low on every rank and flags the data bus as released. Ranks share one calibration resistor, so the windows of the two ranks never overlap. A one-cycle done pulse marks the end of each rank's window. All timing values are cycle-count parameters.

The sequence does not depend on DLL lock. A calibration may therefore run while the DLL reset and lock wait is still in progress.

Top module: `zq_cal_seq`

## Requirements
- R1: A power-up request produces the long command (cmd_o = 3'b010) with a window of T_ZQINIT cycles. A self-refresh-exit request produces the long command with a window of T_ZQOPER cycles. A periodic tick produces the short command (cmd_o = 3'b011) with a window of T_ZQCS cycles. Every self-refresh-exit pulse is served by a long sequence of its own.
- R2: If banks_open_i is set for a rank, its first command is precharge-all (cmd_o = 3'b001), and its calibration command follows exactly T_RP cycles later. If the rank has no open bank, the calibration command is its first command.
- R3: After a calibration command issued in cycle z with window W, cmd_o is NOP (3'b000) in cycles z+1 through z+W-1.
- R4: Ranks are served in order, rank 0 first. The first command of rank 1 comes in cycle z0+W, and never earlier. cs_o is one-hot on the rank that receives a command and zero on NOP cycles.
- R5: While a granted sequence runs, cke_o is all ones and odt_o is all zeros. dq_hiz_o is high from the calibration command through the end of its window. At all other times cke_o follows cke_i, odt_o follows odt_i, and dq_hiz_o is low.
- R6: req_o rises two cycles after the cycle in which a request pulse is present, and stays high until the sequence ends. No command is issued before grant_i is seen. The first command comes in the cycle after the first cycle in which req_o and grant_i are both high. Every cycle without a command shows NOP.
- R7: While per_en_i is high, periodic requests arise every per_ivl_i cycles, so successive periodic req_o rises are per_ivl_i cycles apart.
- R8: Priority is power-up first, then self-refresh exit, then periodic. Starting a long sequence discards any pending periodic request and restarts the timer, so the next periodic req_o rise comes per_ivl_i+1 cycles after the long sequence's req_o rise.
- R9: done_o[r] is a single-cycle pulse in cycle z_r+W. busy_o is high from the req_o rise and falls in the cycle of the last rank's done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| init_cal_i | input | 1 | Power-up calibration request pulse |
| srx_exit_i | input | 1 | Self-refresh-exit calibration request pulse |
| per_en_i | input | 1 | Enables the periodic interval timer |
| per_ivl_i | input | IVL_W | Periodic interval in cycles |
| banks_open_i | input | NUM_RANKS | Per rank: at least one bank is open |
| grant_i | input | 1 | Command arbiter grant, held for the whole sequence |
| cke_i | input | NUM_RANKS | CKE from the main scheduler |
| odt_i | input | NUM_RANKS | ODT from the main scheduler |
| req_o | output | 1 | Request to the command arbiter |
| cmd_o | output | 3 | Command: 0 NOP, 1 precharge-all, 2 long cal, 3 short cal |
| cs_o | output | NUM_RANKS | One-hot target rank of the command |
| cke_o | output | NUM_RANKS | CKE after the sequencer override |
| odt_o | output | NUM_RANKS | ODT after the sequencer override |
| dq_hiz_o | output | 1 | Data bus must be released |
| done_o | output | NUM_RANKS | Per-rank window-end pulse |
| busy_o | output | 1 | A sequence is pending or running |

## Verification
The assertions assume that the arbiter keeps grant_i high for as long as req_o is high once it has granted, and that banks_open_i reflects real bank state when the sequencer samples it. They also assume T_RP and every window length are at least two cycles. The stimulus raises grant_i and leaves it high, or holds it low and then raises it once while a request waits. It changes banks_open_i only while the unit is idle. All timing values it uses are well above the two-cycle floor.

// File: rtl/zq_cal_pkg.sv
package zq_cal_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_PREA = 3'd1,
    CMD_ZQL  = 3'd2,
    CMD_ZQS  = 3'd3
  } zq_cmd_e;

  typedef enum logic [1:0] {
    KIND_INIT = 2'd0,
    KIND_SRX  = 2'd1,
    KIND_PER  = 2'd2
  } zq_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_PREP  = 3'd2,
    ST_TRP   = 3'd3,
    ST_ZQ    = 3'd4,
    ST_QUIET = 3'd5
  } zq_state_e;

  // Quiet-window length that belongs to each trigger kind
  function automatic int unsigned win_cycles(zq_kind_e k, int unsigned t_init,
                                             int unsigned t_oper, int unsigned t_cs);
    case (k)
      KIND_INIT: return t_init;
      KIND_SRX:  return t_oper;
      default:   return t_cs;
    endcase
  endfunction

  // Long form for power-up and self-refresh exit, short form for periodic
  function automatic zq_cmd_e cal_cmd(zq_kind_e k);
    return (k == KIND_PER) ? CMD_ZQS : CMD_ZQL;
  endfunction

endpackage

// File: rtl/zq_period_timer.sv
module zq_period_timer #(
  parameter int IVL_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [IVL_W-1:0] ivl_i,
  output logic             tick_o
);
  logic [IVL_W-1:0] cnt_q;
  logic [IVL_W:0]   next_w;

  assign next_w = {1'b0, cnt_q} + {{IVL_W{1'b0}}, 1'b1};
  assign tick_o = en_i && !restart_i && (next_w >= {1'b0, ivl_i});

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i || !en_i || tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= next_w[IVL_W-1:0];
    end
  end
endmodule

// File: rtl/zq_req_arb.sv
module zq_req_arb
  import zq_cal_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     init_req_i,
  input  logic     srx_req_i,
  input  logic     tick_i,
  input  logic     take_i,
  output logic     pend_o,
  output zq_kind_e kind_o,
  output logic     restart_o
);
  logic init_q, srx_q, per_q;
  logic take_init_w, take_srx_w;

  always_comb begin
    if (init_q)     kind_o = KIND_INIT;
    else if (srx_q) kind_o = KIND_SRX;
    else            kind_o = KIND_PER;
  end

  assign pend_o      = init_q || srx_q || per_q;
  assign take_init_w = take_i && (kind_o == KIND_INIT);
  assign take_srx_w  = take_i && (kind_o == KIND_SRX);
  // A long sequence recalibrates fully, so the interval starts over
  assign restart_o   = take_init_w || take_srx_w;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      init_q <= 1'b0;
      srx_q  <= 1'b0;
      per_q  <= 1'b0;
    end else begin
      init_q <= init_req_i || (init_q && !take_init_w);
      srx_q  <= srx_req_i  || (srx_q  && !take_srx_w);
      per_q  <= tick_i     || (per_q  && !take_i);
    end
  end
endmodule

// File: rtl/zq_seq_fsm.sv
module zq_seq_fsm
  import zq_cal_pkg::*;
#(
  parameter int NUM_RANKS = 2,
  parameter int T_RP      = 6,
  parameter int T_ZQINIT  = 512,
  parameter int T_ZQOPER  = 256,
  parameter int T_ZQCS    = 64,
  parameter int CNT_W     = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pend_i,
  input  zq_kind_e             kind_i,
  input  logic                 grant_i,
  input  logic [NUM_RANKS-1:0] banks_open_i,
  output logic                 take_o,
  output logic                 busy_o,
  output logic                 active_o,
  output zq_cmd_e              cmd_o,
  output logic [NUM_RANKS-1:0] cs_o,
  output logic                 issue_o,
  output logic                 quiet_o,
  output logic [NUM_RANKS-1:0] done_o,
  output logic [CNT_W-1:0]     win_o
);
  localparam int RANK_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1;
  localparam logic [RANK_W-1:0] LAST_RANK = RANK_W'(NUM_RANKS - 1);
  localparam logic [CNT_W-1:0]  ONE       = CNT_W'(1);
  localparam logic [CNT_W-1:0]  RP_LOAD   = CNT_W'(T_RP - 1);

  zq_state_e             state_q, state_d;
  zq_kind_e              kind_q, kind_d;
  logic [RANK_W-1:0]     rank_q, rank_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [NUM_RANKS-1:0]  done_q, done_d;

  assign win_o    = CNT_W'(win_cycles(kind_q, T_ZQINIT, T_ZQOPER, T_ZQCS));
  assign take_o   = (state_q == ST_IDLE) && pend_i;
  assign busy_o   = (state_q != ST_IDLE);
  assign active_o = busy_o && (state_q != ST_REQ);
  assign quiet_o  = (state_q == ST_QUIET);
  assign done_o   = done_q;

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    rank_d  = rank_q;
    cnt_d   = cnt_q;
    done_d  = '0;
    cmd_o   = CMD_NOP;
    issue_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (pend_i) begin
          kind_d  = kind_i;
          state_d = ST_REQ;
        end
      end
      ST_REQ: begin
        if (grant_i) begin
          rank_d  = '0;
          state_d = ST_PREP;
        end
      end
      ST_PREP: begin
        if (banks_open_i[rank_q]) begin
          cmd_o   = CMD_PREA;
          cnt_d   = RP_LOAD;
          state_d = ST_TRP;
        end else begin
          issue_o = 1'b1;
        end
      end
      ST_TRP: begin
        if (cnt_q <= ONE) state_d = ST_ZQ;
        else              cnt_d   = cnt_q - ONE;
      end
      ST_ZQ: issue_o = 1'b1;
      ST_QUIET: begin
        if (cnt_q <= ONE) begin
          done_d[rank_q] = 1'b1;
          if (rank_q == LAST_RANK) begin
            state_d = ST_IDLE;
          end else begin
            rank_d  = rank_q + RANK_W'(1);
            state_d = ST_PREP;
          end
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (issue_o) begin
      cmd_o   = cal_cmd(kind_q);
      cnt_d   = win_o - ONE;
      state_d = ST_QUIET;
    end
  end

  always_comb begin
    cs_o = '0;
    if (cmd_o != CMD_NOP) cs_o[rank_q] = 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= KIND_PER;
      rank_q  <= '0;
      cnt_q   <= '0;
      done_q  <= '0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      rank_q  <= rank_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end
endmodule

// File: rtl/zq_cal_seq.sv
module zq_cal_seq
  import zq_cal_pkg::*;
#(
  parameter int NUM_RANKS = 2,
  parameter int T_RP      = 6,
  parameter int T_ZQINIT  = 512,
  parameter int T_ZQOPER  = 256,
  parameter int T_ZQCS    = 64,
  parameter int CNT_W     = 10,
  parameter int IVL_W     = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 init_cal_i,
  input  logic                 srx_exit_i,
  input  logic                 per_en_i,
  input  logic [IVL_W-1:0]     per_ivl_i,
  input  logic [NUM_RANKS-1:0] banks_open_i,
  input  logic                 grant_i,
  input  logic [NUM_RANKS-1:0] cke_i,
  input  logic [NUM_RANKS-1:0] odt_i,
  output logic                 req_o,
  output logic [2:0]           cmd_o,
  output logic [NUM_RANKS-1:0] cs_o,
  output logic [NUM_RANKS-1:0] cke_o,
  output logic [NUM_RANKS-1:0] odt_o,
  output logic                 dq_hiz_o,
  output logic [NUM_RANKS-1:0] done_o,
  output logic                 busy_o
);
  // Internal events, named for the bound checker
  logic             tick_w, restart_w, pend_w, take_w;
  logic             active_w, zq_issue_w, quiet_w;
  logic [CNT_W-1:0] win_len_w;
  zq_kind_e         kind_w;
  zq_cmd_e          cmd_w;

  zq_period_timer #(.IVL_W(IVL_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (per_en_i),
    .restart_i(restart_w),
    .ivl_i    (per_ivl_i),
    .tick_o   (tick_w)
  );

  zq_req_arb u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .init_req_i(init_cal_i),
    .srx_req_i (srx_exit_i),
    .tick_i    (tick_w),
    .take_i    (take_w),
    .pend_o    (pend_w),
    .kind_o    (kind_w),
    .restart_o (restart_w)
  );

  zq_seq_fsm #(
    .NUM_RANKS(NUM_RANKS), .T_RP(T_RP), .T_ZQINIT(T_ZQINIT),
    .T_ZQOPER(T_ZQOPER), .T_ZQCS(T_ZQCS), .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pend_i      (pend_w),
    .kind_i      (kind_w),
    .grant_i     (grant_i),
    .banks_open_i(banks_open_i),
    .take_o      (take_w),
    .busy_o      (busy_o),
    .active_o    (active_w),
    .cmd_o       (cmd_w),
    .cs_o        (cs_o),
    .issue_o     (zq_issue_w),
    .quiet_o     (quiet_w),
    .done_o      (done_o),
    .win_o       (win_len_w)
  );

  assign req_o    = busy_o;
  assign cmd_o    = cmd_w;
  assign dq_hiz_o = zq_issue_w || quiet_w;

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank_pins
    assign cke_o[r] = active_w ? 1'b1 : cke_i[r];
    assign odt_o[r] = active_w ? 1'b0 : odt_i[r];
  end
endmodule

// File: rtl/zq_cal_seq_chk.sv
module zq_cal_seq_chk #(
  parameter int NUM_RANKS = 2,
  parameter int T_RP      = 6,
  parameter int CNT_W     = 10
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 grant_i,
  input logic                 req_o,
  input logic [2:0]           cmd_o,
  input logic [NUM_RANKS-1:0] cke_o,
  input logic [NUM_RANKS-1:0] odt_o,
  input logic                 dq_hiz_o,
  input logic [NUM_RANKS-1:0] done_o,
  input logic                 zq_issue_w,
  input logic                 quiet_w,
  input logic [CNT_W-1:0]     win_len_w
);
  logic [CNT_W-1:0] since_pre_q;
  logic [CNT_W-1:0] rem_q;
  logic             cal_cmd_w;

  assign cal_cmd_w = (cmd_o == 3'd2) || (cmd_o == 3'd3);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      since_pre_q <= '1;
      rem_q       <= '0;
    end else begin
      if (cmd_o == 3'd1)        since_pre_q <= CNT_W'(1);
      else if (since_pre_q != '1) since_pre_q <= since_pre_q + CNT_W'(1);
      if (cal_cmd_w)            rem_q <= win_len_w - CNT_W'(1);
      else if (rem_q != '0)     rem_q <= rem_q - CNT_W'(1);
    end
  end

  assert_cmd_granted_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != 3'd0) |-> (grant_i && req_o));

  assert_quiet_nop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet_w |-> (cmd_o == 3'd0));

  assert_pins_forced_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zq_issue_w || quiet_w) |-> ((&cke_o) && !(|odt_o) && dq_hiz_o));

  assert_prea_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_cmd_w |-> (since_pre_q >= CNT_W'(T_RP)));

  assert_no_overlap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_cmd_w |-> (rem_q == '0));

  assert_done_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_o));

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_o) |=> !(|done_o));

  assert_done_after_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_o) |-> $past(quiet_w));
endmodule

bind zq_cal_seq zq_cal_seq_chk #(
  .NUM_RANKS(NUM_RANKS), .T_RP(T_RP), .CNT_W(CNT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .grant_i   (grant_i),
  .req_o     (req_o),
  .cmd_o     (cmd_o),
  .cke_o     (cke_o),
  .odt_o     (odt_o),
  .dq_hiz_o  (dq_hiz_o),
  .done_o    (done_o),
  .zq_issue_w(zq_issue_w),
  .quiet_w   (quiet_w),
  .win_len_w (win_len_w)
);

// File: tb/zq_cal_seq_bench.sv
`timescale 1ns/1ps
module zq_cal_seq_bench;
  localparam int NR = 2, TRP = 3, TINIT = 20, TOPER = 12, TCS = 6, CW = 8, IW = 16;
  localparam int PER = 40;
  // vector: [3:2] trigger (1 power-up, 2 self-refresh exit), [1:0] open banks per rank
  localparam logic [3:0] VEC [6] = '{4'b0100, 4'b1001, 4'b1010, 4'b0111, 4'b1011, 4'b1000};

  logic clk = 1'b0, rst_n = 1'b0;
  logic init_cal = 1'b0, srx_exit = 1'b0, per_en = 1'b0, grant = 1'b0;
  logic [IW-1:0] per_ivl = IW'(PER);
  logic [NR-1:0] banks_open = '0, cke_in = 2'b00, odt_in = 2'b11;
  logic req, dq_hiz, busy;
  logic [2:0] cmd;
  logic [NR-1:0] cs, cke_out, odt_out, done;
  int cyc = 0, n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  zq_cal_seq #(.NUM_RANKS(NR), .T_RP(TRP), .T_ZQINIT(TINIT), .T_ZQOPER(TOPER),
               .T_ZQCS(TCS), .CNT_W(CW), .IVL_W(IW)) u_zq_cal_seq (
    .clk_i(clk), .rst_ni(rst_n), .init_cal_i(init_cal), .srx_exit_i(srx_exit),
    .per_en_i(per_en), .per_ivl_i(per_ivl), .banks_open_i(banks_open), .grant_i(grant),
    .cke_i(cke_in), .odt_i(odt_in), .req_o(req), .cmd_o(cmd), .cs_o(cs), .cke_o(cke_out),
    .odt_o(odt_out), .dq_hiz_o(dq_hiz), .done_o(done), .busy_o(busy));

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(150000 * 5);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  task automatic pulse(input int trig);
    @(negedge clk);
    if (trig == 1) init_cal = 1'b1; else srx_exit = 1'b1;
    @(negedge clk);
    init_cal = 1'b0; srx_exit = 1'b0;
  endtask

  // Walks one sequence from its granted request and checks timing against R1-style windows
  task automatic observe_seq(input logic [2:0] ecmd, input int w, input logic [1:0] open,
                             input string tag, output int a);
    int pre_t[2], zq_t[2], done_t[2], done_n[2], zc[2];
    int ncmd, bad_pin, end_t, wd, rk, p0, z0, z1, d0, d1;
    for (int i = 0; i < 2; i++) begin
      pre_t[i] = -1; zq_t[i] = -1; done_t[i] = -1; done_n[i] = 0; zc[i] = -1;
    end
    ncmd = 0; bad_pin = 0; end_t = -1; wd = 0;
    while (!(req && grant) && wd < 2000) begin @(negedge clk); wd++; end
    a = cyc;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      rk = cs[1] ? 1 : 0;
      if (cmd != 3'd0) ncmd++;
      if (cmd == 3'd1) pre_t[rk] = cyc;
      if (cmd == 3'd2 || cmd == 3'd3) begin zq_t[rk] = cyc; zc[rk] = int'(cmd); end
      for (int r = 0; r < 2; r++) if (done[r]) begin done_t[r] = cyc; done_n[r]++; end
      if (dq_hiz && (cke_out != 2'b11 || odt_out != 2'b00)) bad_pin++;
      if (!busy) begin end_t = cyc; break; end
    end
    p0 = a + 1;
    z0 = open[0] ? p0 + TRP : p0;
    d0 = z0 + w;
    z1 = open[1] ? d0 + TRP : d0;
    d1 = z1 + w;
    chk(pre_t[0] == (open[0] ? p0 : -1), {tag, " R2 precharge rank0"}, pre_t[0], open[0] ? p0 : -1);
    chk(zq_t[0] == z0, {tag, " R2 cal cycle rank0"}, zq_t[0], z0);
    chk(zc[0] == int'(ecmd), {tag, " R1 cal kind rank0"}, zc[0], int'(ecmd));
    chk(pre_t[1] == (open[1] ? d0 : -1), {tag, " R4 precharge rank1"}, pre_t[1], open[1] ? d0 : -1);
    chk(zq_t[1] == z1, {tag, " R4 cal cycle rank1"}, zq_t[1], z1);
    chk(zc[1] == int'(ecmd), {tag, " R1 cal kind rank1"}, zc[1], int'(ecmd));
    chk(done_t[0] == d0 && done_n[0] == 1, {tag, " R9 done rank0"}, done_t[0], d0);
    chk(done_t[1] == d1 && done_n[1] == 1, {tag, " R9 done rank1"}, done_t[1], d1);
    chk(end_t == d1, {tag, " R9 busy end"}, end_t, d1);
    chk(ncmd == 2 + int'(open[0]) + int'(open[1]), {tag, " R3 command count"}, ncmd,
        2 + int'(open[0]) + int'(open[1]));
    chk(bad_pin == 0, {tag, " R5 cke/odt forced"}, bad_pin, 0);
    chk(cke_out == cke_in && odt_out == odt_in && !dq_hiz, {tag, " R5 passthrough after"},
        int'({cke_out, odt_out}), int'({cke_in, odt_in}));
  endtask

  initial begin
    int a, as, ap, ap2, n0;
    logic [3:0] v;
    repeat (3) @(negedge clk);
    // reset state
    chk(!req && !busy && cmd == 3'd0 && done == '0, "R6 reset idle", int'({req, busy}), 0);
    chk(cke_out == cke_in && odt_out == odt_in && !dq_hiz, "R5 reset passthrough",
        int'({cke_out, odt_out}), int'({cke_in, odt_in}));
    rst_n = 1'b1;
    grant = 1'b1;
    // vector walk
    for (int i = 0; i < 6; i++) begin
      v = VEC[i];
      @(negedge clk); banks_open = v[1:0];
      pulse(int'(v[3:2]));
      observe_seq(3'd2, (v[3:2] == 2'd1) ? TINIT : TOPER, v[1:0], $sformatf("vec%0d", i), a);
    end
    // R6: request waits for grant; request latency
    grant = 1'b0; banks_open = 2'b01;
    @(negedge clk); srx_exit = 1'b1; n0 = cyc;
    @(negedge clk); srx_exit = 1'b0;
    chk(!req, "R6 req not yet", int'(req), 0);
    @(negedge clk);
    chk(req && cyc == n0 + 2, "R6 req latency", int'(req), 1);
    a = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (cmd != 3'd0 || cke_out != cke_in) a++;
    end
    chk(a == 0 && req, "R6 nothing before grant", a, 0);
    grant = 1'b1;
    observe_seq(3'd2, TOPER, 2'b01, "grant", a);
    // R1/R8: power-up and self-refresh together, power-up first
    banks_open = 2'b11; per_en = 1'b1;
    @(negedge clk); init_cal = 1'b1; srx_exit = 1'b1;
    @(negedge clk); init_cal = 1'b0; srx_exit = 1'b0;
    observe_seq(3'd2, TINIT, 2'b11, "R8 init first", a);
    // periodic tick pended during that sequence is dropped by the self-refresh one
    observe_seq(3'd2, TOPER, 2'b11, "R8 srx second", as);
    banks_open = 2'b00;
    observe_seq(3'd3, TCS, 2'b00, "R7 periodic", ap);
    chk(ap == as + PER + 1, "R8 timer restart", ap - as, PER + 1);
    observe_seq(3'd3, TCS, 2'b00, "R7 periodic2", ap2);
    chk(ap2 == ap + PER, "R7 periodic spacing", ap2 - ap, PER);
    per_en = 1'b0;
    repeat (PER + 5) @(negedge clk);
    chk(!busy && !req, "R7 timer disabled", int'(busy), 0);
    finish_run();
  end
endmodule